// File: doc/BRIEF.md
# Four-State Moore Sequence Controller

This block is a small clocked control machine with four states, one single-bit input and one single-bit output. The state is kept in a two-bit register. The output is decoded from that register alone, so a change on the input can never reach the output inside a cycle. The state advances on a rising clock edge when the clock enable is high. This lets the machine sit inside a datapath that runs at a fraction of the clock rate.

Two of the four states (codes 2 and 3) are never entered from reset by any input sequence. A load port lets a test environment write any state code straight into the register, so the transitions out of those two states can still be tested. The register also drives a state observation port so that its value can be read back. A parameter can remove the load path; the load inputs are then ignored.

Top module: `seq4_moore`

## Requirements
- R1: State codes are 0 (first state), 1, 2 and 3, and are shown on `state_o`. After a synchronous reset `state_o` is 0 and `z_out` is 1.
- R2: While `rst` is high at a rising edge, the state becomes 0. Reset wins over the load port and over the clock enable.
- R3: `z_out` is 1 when the state is 0 or 3, and 0 when the state is 1 or 2.
- R4: From state 0, an enabled edge moves to state 0 when `a_in` is 0 and to state 1 when `a_in` is 1.
- R5: From state 1, an enabled edge moves to state 0 when `a_in` is 0 and to state 1 when `a_in` is 1.
- R6: From state 2, an enabled edge moves to state 1 when `a_in` is 0 and to state 2 when `a_in` is 1.
- R7: From state 3, an enabled edge moves to state 0 when `a_in` is 0 and to state 2 when `a_in` is 1.
- R8: When `ce` is low and neither reset nor load is active, the state holds at every edge.
- R9: When `load_en` is high and `rst` is low at an edge, the state becomes `load_state`. This happens whatever `ce` is, and the load wins over the normal advance.
- R10: Changing `a_in` between clock edges never changes `z_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the state advance |
| a_in | input | 1 | Control input that steers the transitions |
| load_en | input | 1 | Loads `load_state` straight into the state register |
| load_state | input | 2 | State code to load |
| z_out | output | 1 | Moore output, decoded from the state |
| state_o | output | 2 | Current state code |

## Verification
A wrong next-state entry is seen on `state_o` one enabled edge after the state and input pair that selects it. It is seen on `z_out` in the same cycle whenever the wrong state has a different output value. A wrong output decode is seen at once on `z_out`, as soon as the state is loaded. A path from the input to the output shows up as `z_out` changing between edges while `a_in` is toggled. The unreachable states are reached only through the load port, so each pair is set up in one cycle and its result is checked on the next enabled edge.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
   localparam int STATE_W = 2;
   localparam int NUM_STATES = 1 << STATE_W;

   typedef enum logic [STATE_W-1:0] {
      ST_REST = 2'd0,
      ST_ARM  = 2'd1,
      ST_HOLD = 2'd2,
      ST_EXIT = 2'd3
   } state_t;
endpackage

// File: rtl/seq4_next.sv
module seq4_next
   import seq4_pkg::*;
(
   input  state_t cur,
   input  logic   a,
   output state_t nxt
);
   always_comb begin
      unique case (cur)
         ST_REST: nxt = a ? ST_ARM  : ST_REST;
         ST_ARM:  nxt = a ? ST_ARM  : ST_REST;
         ST_HOLD: nxt = a ? ST_HOLD : ST_ARM;
         ST_EXIT: nxt = a ? ST_HOLD : ST_REST;
         default: nxt = ST_REST;
      endcase
   end
endmodule

// File: rtl/seq4_decode.sv
module seq4_decode
   import seq4_pkg::*;
#(
   parameter logic [NUM_STATES-1:0] Z_MAP = 4'b1001
)(
   input  state_t cur,
   output logic   z
);
   if (NUM_STATES != 4) begin : g_chk_states
      $error("seq4_decode: output map expects exactly four states");
   end

   // Bit i of Z_MAP is the output value in state code i.
   assign z = Z_MAP[cur];
endmodule

// File: rtl/seq4_state_reg.sv
module seq4_state_reg
   import seq4_pkg::*;
#(
   parameter bit HOOK_EN = 1'b1
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                ce,
   input  logic                load_en,
   input  logic [STATE_W-1:0]  load_state,
   input  state_t              nxt,
   output state_t              state_q
);
   logic   do_load;
   state_t load_val;

   if (HOOK_EN) begin : g_hook
      assign do_load  = load_en;
      assign load_val = state_t'(load_state);
   end else begin : g_no_hook
      logic unused_hook;
      assign unused_hook = load_en ^ (^load_state);
      assign do_load  = 1'b0;
      assign load_val = ST_REST;
   end

   always_ff @(posedge clk) begin
      if (rst)          state_q <= ST_REST;
      else if (do_load) state_q <= load_val;
      else if (ce)      state_q <= nxt;
   end

   // R2: reset places the first state
   p_reset_rest_r2: assert property (@(posedge clk) rst |=> state_q == ST_REST);

   // R8: no enable, no load -> hold
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!ce && !do_load) |=> $stable(state_q));

   if (HOOK_EN) begin : g_hook_chk
      // R9: load writes the requested code
      p_load_r9: assert property (@(posedge clk) disable iff (rst)
         load_en |=> state_q == $past(load_state));
   end
endmodule

// File: rtl/seq4_moore.sv
module seq4_moore
   import seq4_pkg::*;
#(
   parameter bit                    HOOK_EN = 1'b1,
   parameter logic [NUM_STATES-1:0] Z_MAP   = 4'b1001
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               ce,
   input  logic               a_in,
   input  logic               load_en,
   input  logic [STATE_W-1:0] load_state,
   output logic               z_out,
   output logic [STATE_W-1:0] state_o
);
   state_t cur_s;
   state_t nxt_s;

   seq4_next u_next (
      .cur (cur_s),
      .a   (a_in),
      .nxt (nxt_s)
   );

   seq4_state_reg #(.HOOK_EN(HOOK_EN)) u_reg (
      .clk        (clk),
      .rst        (rst),
      .ce         (ce),
      .load_en    (load_en),
      .load_state (load_state),
      .nxt        (nxt_s),
      .state_q    (cur_s)
   );

   seq4_decode #(.Z_MAP(Z_MAP)) u_dec (
      .cur (cur_s),
      .z   (z_out)
   );

   assign state_o = cur_s;

   // R10: output follows state only
   p_z_tracks_state_r10: assert property (@(posedge clk) disable iff (rst)
      $stable(state_o) |-> $stable(z_out));

   // R7: state 3 with input high goes to state 2
   p_exit_to_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ce && !load_en && state_o == 2'd3 && a_in) |=> state_o == 2'd2);

   // R6: state 2 with input low goes to state 1
   p_hold_to_arm_r6: assert property (@(posedge clk) disable iff (rst)
      (ce && !load_en && state_o == 2'd2 && !a_in) |=> state_o == 2'd1);

   // R4: state 0 with input high goes to state 1
   p_rest_to_arm_r4: assert property (@(posedge clk) disable iff (rst)
      (ce && !load_en && state_o == 2'd0 && a_in) |=> state_o == 2'd1);
endmodule

// File: tb/seq4_moore_tb_top.sv
`timescale 1ns/1ps
module seq4_moore_tb_top;
   logic       clk = 1'b0;
   logic       rst, ce, a_in, load_en;
   logic [1:0] load_state;
   logic       z_out;
   logic [1:0] state_o;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   seq4_moore dut_i (
      .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .load_en(load_en),
      .load_state(load_state), .z_out(z_out), .state_o(state_o)
   );

   // fields: current state, input, expected next state
   localparam logic [4:0] VEC [0:7] = '{
      5'b00_0_00, 5'b00_1_01,
      5'b01_0_00, 5'b01_1_01,
      5'b10_0_01, 5'b10_1_10,
      5'b11_0_00, 5'b11_1_10
   };

   function automatic logic zexp(input logic [1:0] s);
      return (s == 2'd0) || (s == 2'd3);   // R3
   endfunction

   function automatic string rtag(input logic [1:0] s);
      case (s)
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; ce = 1'b0; a_in = 1'b0; load_en = 1'b0; load_state = 2'd0;
      tick(); tick(); tick();
      rst = 1'b0;
      chk("R1 state", state_o, 2'd0);
      chk("R1 z", {1'b0, z_out}, 2'd1);

      for (int i = 0; i < 8; i++) begin
         logic [1:0] cs;
         logic       av;
         logic [1:0] ns;
         logic       zh;
         cs = VEC[i][4:3];
         av = VEC[i][2];
         ns = VEC[i][1:0];
         load_en = 1'b1; load_state = cs; ce = 1'b0;
         tick();
         load_en = 1'b0;
         chk("R9 load", state_o, cs);
         chk("R3 decode", {1'b0, z_out}, {1'b0, zexp(cs)});
         zh = z_out;
         a_in = ~av; #0.5;
         chk("R10 z vs a", {1'b0, z_out}, {1'b0, zh});
         a_in = av;  #0.5;
         chk("R10 z vs a", {1'b0, z_out}, {1'b0, zh});
         ce = 1'b1;
         tick();
         ce = 1'b0;
         chk(rtag(cs), state_o, ns);
         chk("R3 after step", {1'b0, z_out}, {1'b0, zexp(ns)});
      end

      // R8: enable low holds state 2 for several edges
      load_en = 1'b1; load_state = 2'd2; tick(); load_en = 1'b0;
      a_in = 1'b0; ce = 1'b0;
      tick(); tick(); tick();
      chk("R8 hold", state_o, 2'd2);

      // R9: load beats the enabled advance
      ce = 1'b1; a_in = 1'b1; load_en = 1'b1; load_state = 2'd3;
      tick();
      load_en = 1'b0; ce = 1'b0;
      chk("R9 priority", state_o, 2'd3);

      // R2: reset beats load and enable
      rst = 1'b1; load_en = 1'b1; load_state = 2'd3; ce = 1'b1;
      tick();
      rst = 1'b0; load_en = 1'b0; ce = 1'b0;
      chk("R2 priority", state_o, 2'd0);
      chk("R1 z after reset", {1'b0, z_out}, 2'd1);

      // walk from reset: 0 -a1-> 1 -a1-> 1 -a0-> 0
      ce = 1'b1; a_in = 1'b1; tick();
      chk("R4 walk", state_o, 2'd1);
      tick();
      chk("R5 walk", state_o, 2'd1);
      a_in = 1'b0; tick();
      chk("R5 walk back", state_o, 2'd0);
      ce = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule